// File: doc/BRIEF.md
# Console Bus Address Decoder with Access-Speed Control

This block sits on the 24-bit address bus of a console CPU and works out, for every access, which device should answer. The address is split into an 8-bit bank (bits 23:16) and a 16-bit offset (bits 15:0). Each cycle the decoder raises one of five selects: system work RAM, memory-mapped I/O, cartridge ROM, cartridge save RAM, or open bus (nothing answers). Along with the select it gives the device-relative ROM or save-RAM address, and a speed class telling the bus-cycle logic whether the access may run fast or must run slow.

Two static board straps shape the map. The layout strap picks a layout with 32 KiB of ROM per bank or one with 64 KiB per bank. The save-RAM strap picks, in the 32 KiB layout only, whether save RAM fills half or all of its banks. A one-bit speed register, written by software through the I/O banks, decides whether ROM in the upper half of the bank space runs fast. ROM in the lower half always stays slow. All outputs are registered, so each one reflects the address presented one clock edge earlier.

Top module: `bus_map_decoder`

## Requirements
- R1: Reset is synchronous and active high. During and right after reset the outputs show open bus with fast=0. After reset exactly one of sel_wram, sel_io, sel_rom, sel_sram and sel_open is high in every cycle. Each output shows the decode of the inputs sampled at the previous rising clock edge.
- R2: Work RAM is selected in either layout for offsets 0x0000-0x1FFF of every bank with bank bit 6 = 0, and for every offset of banks 0x7E and 0x7F.
- R3: I/O is selected in either layout for offsets 0x2000-0x5FFF of every bank with bank bit 6 = 0.
- R4: With map_hi=0 (32 KiB layout), ROM is selected when offset bit 15 = 1, unless work RAM or save RAM claims the address. In that case rom_addr = {bank[6:0], offset[14:0]}.
- R5: With map_hi=0, save RAM is selected in banks 0x70-0x7D and 0xF0-0xFF. With sram_full=0 it covers offsets 0x0000-0x7FFF and sram_addr = {1'b0, bank[3:0], offset[14:0]}. With sram_full=1 it covers all offsets and sram_addr = {bank[3:0], offset}. Save RAM takes priority over ROM.
- R6: With map_hi=1 (64 KiB layout), ROM is selected for offsets 0x8000-0xFFFF of banks with bank bit 6 = 0, and for every offset of banks 0x40-0x7D and 0xC0-0xFF. In that case rom_addr = {bank[5:0], offset}.
- R7: With map_hi=1, save RAM is selected only in banks 0x20-0x3F and 0xA0-0xBF at offsets 0x6000-0x7FFF, with sram_addr = {2'b00, bank[4:0], offset[12:0]}. The sram_full input has no effect in this layout.
- R8: Any address claimed by no region selects open bus. rom_addr is zero whenever sel_rom is low, and sram_addr is zero whenever sel_sram is low.
- R9: The speed register resets to 0. It is loaded with wr_bit when wr_en=1, bank bit 6 = 0 and offset = 0x420D, and the new value applies from the next access on. A write with any other offset, in a bank with bit 6 = 1, or with wr_en=0 leaves it unchanged.
- R10: fast=1 only when ROM is selected, bank bit 7 = 1 and the speed register holds 1. ROM in banks 0x00-0x7F, including the 64 KiB-layout mirror in banks 0x40-0x7D, is always slow. Work RAM, I/O, save RAM and open bus are always slow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| map_hi | input | 1 | Layout strap: 0 = 32 KiB per bank, 1 = 64 KiB per bank |
| sram_full | input | 1 | Save-RAM strap for the 32 KiB layout: 1 = whole bank, 0 = lower half |
| addr_bank | input | 8 | Bank part of the address (bits 23:16) |
| addr_off | input | 16 | Offset part of the address (bits 15:0) |
| wr_en | input | 1 | The current access is a write |
| wr_bit | input | 1 | Data bit 0 of the write |
| sel_wram | output | 1 | Work RAM select |
| sel_io | output | 1 | Memory-mapped I/O select |
| sel_rom | output | 1 | Cartridge ROM select |
| sel_sram | output | 1 | Cartridge save-RAM select |
| sel_open | output | 1 | Open-bus select |
| rom_addr | output | 22 | Device-relative ROM address |
| sram_addr | output | 20 | Device-relative save-RAM address |
| fast | output | 1 | Speed class: 1 = fast, 0 = slow |

## Verification
The bench builds the decoder with its default speed-register offset of 0x420D. Its address sweep covers both layouts and both save-RAM straps, so it reaches the region edges at offsets 0x1FFF/0x2000, 0x5FFF/0x6000 and 0x7FFF/0x8000, and the bank edges at 0x6F/0x70, 0x7D/0x7E, 0x1F/0x20 and 0xEF/0xF0. The same sweep runs once with the speed register clear and once with it set, which shows that only upper-bank ROM changes class. Directed writes then hit near-miss offsets, non-I/O banks and disabled writes, and a mid-run reset is applied.

// File: rtl/bmd_pkg.sv
package bmd_pkg;
  localparam int BANK_W  = 8;
  localparam int OFF_W   = 16;
  localparam int ROM_AW  = (BANK_W - 1) + (OFF_W - 1);
  localparam int SRAM_AW = OFF_W + 4;
  localparam int NUM_RG  = 5;

  typedef enum logic [2:0] {
    RG_OPEN = 3'd0,
    RG_SRAM = 3'd1,
    RG_ROM  = 3'd2,
    RG_IO   = 3'd3,
    RG_WRAM = 3'd4
  } region_e;

  typedef struct packed {
    logic               sram_hit;
    logic               rom_hit;
    logic [ROM_AW-1:0]  rom_addr;
    logic [SRAM_AW-1:0] sram_addr;
  } map_res_t;
endpackage

// File: rtl/bmd_lo_map.sv
module bmd_lo_map
  import bmd_pkg::*;
(
  input  logic [BANK_W-1:0] bank,
  input  logic [OFF_W-1:0]  off,
  input  logic              sram_full,
  output map_res_t          res
);
  logic in_sram_bank;

  always_comb begin
    // save RAM banks of the 32 KiB layout
    in_sram_bank  = ((bank >= 8'h70) && (bank <= 8'h7D)) || (bank >= 8'hF0);
    res.sram_hit  = in_sram_bank && (sram_full || !off[OFF_W-1]);
    res.rom_hit   = off[OFF_W-1];
    res.rom_addr  = {bank[BANK_W-2:0], off[OFF_W-2:0]};
    res.sram_addr = sram_full ? {bank[3:0], off}
                              : {1'b0, bank[3:0], off[OFF_W-2:0]};
  end
endmodule

// File: rtl/bmd_hi_map.sv
module bmd_hi_map
  import bmd_pkg::*;
(
  input  logic [BANK_W-2:0] bank_lo,
  input  logic [OFF_W-1:0]  off,
  output map_res_t          res
);
  always_comb begin
    res.sram_hit  = (bank_lo[6:5] == 2'b01) && (off[15:13] == 3'b011);
    // whole-bank ROM above bank bit 6, upper half elsewhere
    res.rom_hit   = bank_lo[6] ? 1'b1 : off[OFF_W-1];
    res.rom_addr  = {bank_lo[5:0], off};
    res.sram_addr = {{(SRAM_AW-18){1'b0}}, bank_lo[4:0], off[12:0]};
  end
endmodule

// File: rtl/bmd_speed_reg.sv
module bmd_speed_reg #(
  parameter int              OFF_W   = 16,
  parameter logic [OFF_W-1:0] REG_OFF = 16'h420D
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             io_bank,
  input  logic [OFF_W-1:0] off,
  input  logic             wr_bit,
  output logic             fast_en
);
  always_ff @(posedge clk) begin
    if (rst) begin
      fast_en <= 1'b0;
    end else if (wr_en && io_bank && (off == REG_OFF)) begin
      fast_en <= wr_bit;
    end
  end
endmodule

// File: rtl/bus_map_decoder.sv
module bus_map_decoder
  import bmd_pkg::*;
#(
  parameter logic [15:0] SPEED_OFF = 16'h420D
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               map_hi,
  input  logic               sram_full,
  input  logic [BANK_W-1:0]  addr_bank,
  input  logic [OFF_W-1:0]   addr_off,
  input  logic               wr_en,
  input  logic               wr_bit,
  output logic               sel_wram,
  output logic               sel_io,
  output logic               sel_rom,
  output logic               sel_sram,
  output logic               sel_open,
  output logic [ROM_AW-1:0]  rom_addr,
  output logic [SRAM_AW-1:0] sram_addr,
  output logic               fast
);
  logic               io_bank;
  logic               wram_hit;
  logic               io_hit;
  logic               fast_en;
  map_res_t           lo_res;
  map_res_t           hi_res;
  map_res_t           res;
  region_e            region_n;
  logic [NUM_RG-1:0]  sel_n;
  logic [NUM_RG-1:0]  sel_q;
  logic [ROM_AW-1:0]  rom_n;
  logic [SRAM_AW-1:0] sram_n;
  logic               fast_n;
  logic [ROM_AW-1:0]  rom_q;
  logic [SRAM_AW-1:0] sram_q;
  logic               fast_q;

  assign io_bank = !addr_bank[BANK_W-2];

  bmd_lo_map u_lo (
    .bank      (addr_bank),
    .off       (addr_off),
    .sram_full (sram_full),
    .res       (lo_res)
  );

  bmd_hi_map u_hi (
    .bank_lo (addr_bank[BANK_W-2:0]),
    .off     (addr_off),
    .res     (hi_res)
  );

  bmd_speed_reg #(
    .OFF_W   (OFF_W),
    .REG_OFF (SPEED_OFF)
  ) u_speed (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .io_bank (io_bank),
    .off     (addr_off),
    .wr_bit  (wr_bit),
    .fast_en (fast_en)
  );

  always_comb begin
    wram_hit = (io_bank && (addr_off < 16'h2000)) || (addr_bank[BANK_W-1:1] == 7'h3F);
    io_hit   = io_bank && (addr_off >= 16'h2000) && (addr_off < 16'h6000);
    res      = map_hi ? hi_res : lo_res;
    if (wram_hit)          region_n = RG_WRAM;
    else if (io_hit)       region_n = RG_IO;
    else if (res.sram_hit) region_n = RG_SRAM;
    else if (res.rom_hit)  region_n = RG_ROM;
    else                   region_n = RG_OPEN;
    rom_n  = (region_n == RG_ROM)  ? res.rom_addr  : '0;
    sram_n = (region_n == RG_SRAM) ? res.sram_addr : '0;
    fast_n = (region_n == RG_ROM) && addr_bank[BANK_W-1] && fast_en;
  end

  for (genvar g = 0; g < NUM_RG; g++) begin : g_sel
    assign sel_n[g] = (region_n == region_e'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= NUM_RG'(1) << RG_OPEN;
      rom_q  <= '0;
      sram_q <= '0;
      fast_q <= 1'b0;
    end else begin
      sel_q  <= sel_n;
      rom_q  <= rom_n;
      sram_q <= sram_n;
      fast_q <= fast_n;
    end
  end

  assign sel_wram  = sel_q[RG_WRAM];
  assign sel_io    = sel_q[RG_IO];
  assign sel_rom   = sel_q[RG_ROM];
  assign sel_sram  = sel_q[RG_SRAM];
  assign sel_open  = sel_q[RG_OPEN];
  assign rom_addr  = rom_q;
  assign sram_addr = sram_q;
  assign fast      = fast_q;
endmodule

// File: rtl/bus_map_decoder_chk.sv
module bus_map_decoder_chk (
  input logic        clk,
  input logic        rst,
  input logic        map_hi,
  input logic [7:0]  addr_bank,
  input logic [15:0] addr_off,
  input logic        wr_en,
  input logic        wr_bit,
  input logic        sel_wram,
  input logic        sel_io,
  input logic        sel_rom,
  input logic        sel_sram,
  input logic        sel_open,
  input logic [21:0] rom_addr,
  input logic [19:0] sram_addr,
  input logic        fast
);
  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (rst)
    $countones({sel_wram, sel_io, sel_rom, sel_sram, sel_open}) == 1); // R1

  AST_WRAM_BANKS: assert property (@(posedge clk) disable iff (rst)
    sel_wram |-> ($past(!addr_bank[6]) || ($past(addr_bank[7:1]) == 7'h3F))); // R2

  AST_IO_WINDOW: assert property (@(posedge clk) disable iff (rst)
    sel_io |-> ($past(!addr_bank[6]) && ($past(addr_off) >= 16'h2000)
                && ($past(addr_off) < 16'h6000))); // R3

  AST_HI_SRAM_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (sel_sram && $past(map_hi)) |-> ($past(addr_off[15:13]) == 3'b011)); // R7

  AST_IDLE_ADDR_ZERO: assert property (@(posedge clk) disable iff (rst)
    ((!sel_rom) |-> (rom_addr == 22'd0)) and ((!sel_sram) |-> (sram_addr == 20'd0))); // R8

  AST_SPEED_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en && !addr_bank[6] && (addr_off == 16'h420D) && !wr_bit) |=> !fast); // R9

  AST_FAST_UPPER_ROM: assert property (@(posedge clk) disable iff (rst)
    fast |-> (sel_rom && $past(addr_bank[7]))); // R10
endmodule

bind bus_map_decoder bus_map_decoder_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .map_hi    (map_hi),
  .addr_bank (addr_bank),
  .addr_off  (addr_off),
  .wr_en     (wr_en),
  .wr_bit    (wr_bit),
  .sel_wram  (sel_wram),
  .sel_io    (sel_io),
  .sel_rom   (sel_rom),
  .sel_sram  (sel_sram),
  .sel_open  (sel_open),
  .rom_addr  (rom_addr),
  .sram_addr (sram_addr),
  .fast      (fast)
);

// File: tb/bus_map_decoder_bench.sv
module bus_map_decoder_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        map_hi = 1'b0;
  logic        sram_full = 1'b0;
  logic [7:0]  addr_bank = 8'h00;
  logic [15:0] addr_off = 16'h0000;
  logic        wr_en = 1'b0;
  logic        wr_bit = 1'b0;
  logic        sel_wram, sel_io, sel_rom, sel_sram, sel_open, fast;
  logic [21:0] rom_addr;
  logic [19:0] sram_addr;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bus_map_decoder u_bus_map_decoder (
    .clk(clk), .rst(rst), .map_hi(map_hi), .sram_full(sram_full),
    .addr_bank(addr_bank), .addr_off(addr_off), .wr_en(wr_en), .wr_bit(wr_bit),
    .sel_wram(sel_wram), .sel_io(sel_io), .sel_rom(sel_rom), .sel_sram(sel_sram),
    .sel_open(sel_open), .rom_addr(rom_addr), .sram_addr(sram_addr), .fast(fast)
  );

  // select vector order {wram, io, rom, sram, open}
  localparam logic [4:0] S_W = 5'b10000;
  localparam logic [4:0] S_I = 5'b01000;
  localparam logic [4:0] S_R = 5'b00100;
  localparam logic [4:0] S_S = 5'b00010;
  localparam logic [4:0] S_O = 5'b00001;

  typedef struct packed {
    logic        m;
    logic        f;
    logic [7:0]  b;
    logic [15:0] o;
    logic [4:0]  s;
    logic [21:0] r;
    logic [19:0] a;
  } vec_t;

  localparam int NV = 32;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 8'h00, 16'h0000, S_W, 22'h0, 20'h0},
    '{1'b0, 1'b0, 8'h80, 16'h1FFF, S_W, 22'h0, 20'h0},
    '{1'b0, 1'b0, 8'h7E, 16'h8000, S_W, 22'h0, 20'h0},
    '{1'b1, 1'b0, 8'h7F, 16'h1234, S_W, 22'h0, 20'h0},
    '{1'b0, 1'b0, 8'h00, 16'h2100, S_I, 22'h0, 20'h0},
    '{1'b0, 1'b0, 8'hBF, 16'h5FFF, S_I, 22'h0, 20'h0},
    '{1'b0, 1'b0, 8'h00, 16'h6000, S_O, 22'h0, 20'h0},
    '{1'b0, 1'b0, 8'h01, 16'h8123, S_R, 22'h008123, 20'h0},
    '{1'b0, 1'b0, 8'h85, 16'hFFFF, S_R, 22'h02FFFF, 20'h0},
    '{1'b0, 1'b0, 8'h40, 16'h8000, S_R, 22'h200000, 20'h0},
    '{1'b0, 1'b0, 8'h40, 16'h0000, S_O, 22'h0, 20'h0},
    '{1'b0, 1'b0, 8'h71, 16'h7FFF, S_S, 22'h0, 20'h0FFFF},
    '{1'b0, 1'b0, 8'h71, 16'h8000, S_R, 22'h388000, 20'h0},
    '{1'b0, 1'b1, 8'h71, 16'h8000, S_S, 22'h0, 20'h18000},
    '{1'b0, 1'b1, 8'hFF, 16'hFFFF, S_S, 22'h0, 20'hFFFFF},
    '{1'b0, 1'b0, 8'hFF, 16'h8001, S_R, 22'h3F8001, 20'h0},
    '{1'b0, 1'b0, 8'hF0, 16'h0000, S_S, 22'h0, 20'h0},
    '{1'b0, 1'b0, 8'h6F, 16'h0000, S_O, 22'h0, 20'h0},
    '{1'b0, 1'b1, 8'h7D, 16'h0000, S_S, 22'h0, 20'hD0000},
    '{1'b0, 1'b0, 8'hEF, 16'h7FFF, S_O, 22'h0, 20'h0},
    '{1'b1, 1'b0, 8'h00, 16'h8000, S_R, 22'h008000, 20'h0},
    '{1'b1, 1'b0, 8'h3F, 16'hFFFF, S_R, 22'h3FFFFF, 20'h0},
    '{1'b1, 1'b0, 8'h41, 16'h0010, S_R, 22'h010010, 20'h0},
    '{1'b1, 1'b0, 8'hC0, 16'h1234, S_R, 22'h001234, 20'h0},
    '{1'b1, 1'b0, 8'h7D, 16'hFFFF, S_R, 22'h3DFFFF, 20'h0},
    '{1'b1, 1'b0, 8'h21, 16'h6001, S_S, 22'h0, 20'h02001},
    '{1'b1, 1'b0, 8'hBF, 16'h7FFF, S_S, 22'h0, 20'h3FFFF},
    '{1'b1, 1'b0, 8'h1F, 16'h6000, S_O, 22'h0, 20'h0},
    '{1'b1, 1'b0, 8'h00, 16'h5FFF, S_I, 22'h0, 20'h0},
    '{1'b1, 1'b1, 8'h70, 16'h0000, S_R, 22'h300000, 20'h0},
    '{1'b1, 1'b1, 8'h20, 16'h8000, S_R, 22'h208000, 20'h0},
    '{1'b1, 1'b0, 8'h80, 16'h6000, S_O, 22'h0, 20'h0}
  };

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // present one access, then wait until its registered result is visible
  task automatic apply(input logic m, input logic f, input logic [7:0] b,
                       input logic [15:0] o, input logic we, input logic wb);
    map_hi = m; sram_full = f; addr_bank = b; addr_off = o;
    wr_en = we; wr_bit = wb;
    @(negedge clk);
  endtask

  function automatic string region_tag(input logic [4:0] s, input logic m);
    case (s)
      S_W:     return "R2";
      S_I:     return "R3";
      S_R:     return m ? "R6" : "R4";
      S_S:     return m ? "R7" : "R5";
      default: return "R8";
    endcase
  endfunction

  task automatic sweep(input logic speed_set);
    for (int i = 0; i < NV; i++) begin
      logic exp_fast;
      apply(VEC[i].m, VEC[i].f, VEC[i].b, VEC[i].o, 1'b0, 1'b0);
      exp_fast = speed_set && (VEC[i].s == S_R) && VEC[i].b[7];
      check(region_tag(VEC[i].s, VEC[i].m), $sformatf("vec%0d select", i),
            {27'd0, sel_wram, sel_io, sel_rom, sel_sram, sel_open}, {27'd0, VEC[i].s});
      check(region_tag(VEC[i].s, VEC[i].m), $sformatf("vec%0d rom_addr", i),
            {10'd0, rom_addr}, {10'd0, VEC[i].r});
      check(region_tag(VEC[i].s, VEC[i].m), $sformatf("vec%0d sram_addr", i),
            {12'd0, sram_addr}, {12'd0, VEC[i].a});
      check("R10", $sformatf("vec%0d fast", i), {31'd0, fast}, {31'd0, exp_fast});
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "reset select", {27'd0, sel_wram, sel_io, sel_rom, sel_sram, sel_open}, {27'd0, S_O});
    check("R1", "reset fast", {31'd0, fast}, 32'd0);
    rst = 1'b0;

    // speed register clear: no fast ROM anywhere (R9 reset value, R10)
    sweep(1'b0);

    // R9: set the speed register; the write cycle itself decodes as slow I/O
    apply(1'b0, 1'b0, 8'h00, 16'h420D, 1'b1, 1'b1);
    check("R9", "write cycle io", {31'd0, sel_io}, 32'd1);
    check("R9", "write cycle fast", {31'd0, fast}, 32'd0);
    apply(1'b0, 1'b0, 8'h80, 16'h8000, 1'b0, 1'b0);
    check("R9", "fast on next access", {31'd0, fast}, 32'd1);

    // speed register set: only upper-bank ROM becomes fast (R10)
    sweep(1'b1);

    // R9: ignored writes keep fast
    apply(1'b0, 1'b0, 8'h00, 16'h420C, 1'b1, 1'b0);
    apply(1'b0, 1'b0, 8'h80, 16'h8000, 1'b0, 1'b0);
    check("R9", "near-miss offset ignored", {31'd0, fast}, 32'd1);
    apply(1'b0, 1'b0, 8'h40, 16'h420D, 1'b1, 1'b0);
    apply(1'b0, 1'b0, 8'h80, 16'h8000, 1'b0, 1'b0);
    check("R9", "non-io bank ignored", {31'd0, fast}, 32'd1);
    apply(1'b0, 1'b0, 8'h00, 16'h420D, 1'b0, 1'b0);
    apply(1'b0, 1'b0, 8'h80, 16'h8000, 1'b0, 1'b0);
    check("R9", "read ignored", {31'd0, fast}, 32'd1);
    apply(1'b1, 1'b0, 8'hC5, 16'h0000, 1'b0, 1'b0);
    check("R10", "hi layout upper ROM fast", {31'd0, fast}, 32'd1);
    apply(1'b1, 1'b0, 8'h45, 16'h0000, 1'b0, 1'b0);
    check("R10", "hi mirror slow", {31'd0, fast}, 32'd0);
    apply(1'b1, 1'b0, 8'hA0, 16'h6000, 1'b0, 1'b0);
    check("R10", "upper save RAM slow", {31'd0, fast}, 32'd0);

    // R9: clear through the mirror I/O bank
    apply(1'b0, 1'b0, 8'h80, 16'h420D, 1'b1, 1'b0);
    apply(1'b0, 1'b0, 8'h80, 16'h8000, 1'b0, 1'b0);
    check("R9", "cleared via bank 80", {31'd0, fast}, 32'd0);

    // set again, then reset mid-run
    apply(1'b0, 1'b0, 8'h3F, 16'h420D, 1'b1, 1'b1);
    apply(1'b0, 1'b0, 8'hFF, 16'h8000, 1'b0, 1'b0);
    check("R9", "set via bank 3F", {31'd0, fast}, 32'd1);
    rst = 1'b1;
    @(negedge clk);
    check("R1", "mid reset select", {27'd0, sel_wram, sel_io, sel_rom, sel_sram, sel_open}, {27'd0, S_O});
    rst = 1'b0;
    apply(1'b0, 1'b0, 8'hFF, 16'h8000, 1'b0, 1'b0);
    check("R9", "reset clears speed", {31'd0, fast}, 32'd0);
    check("R4", "rom after reset", {31'd0, sel_rom}, 32'd1);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule